// File: doc/BRIEF.md
# Port Blockage Rate Monitor

This block watches one processing core's two stream ports and turns their transfer outcomes into clock-step requests. Every cycle each port may report a successful transfer, a blocked attempt, or both. A per-port signed tally moves up by one on a blocked attempt and down by one on a success, and it saturates at its signed limits rather than wrapping.

When the evaluation strobe is seen, the block judges each tally against a programmable signed threshold. It then issues a one-cycle request to step the core clock up, to step it down, or to leave it alone, and it clears both tallies so that the next window starts from zero. A starved core, where the input side keeps blocking and the output side does not, asks for more speed. A core that stalls on its output while its input flows freely asks for less. Clock generation and supply control sit outside this block and consume the two request pulses.

Top module: `rate_blockage_monitor`

## Requirements
- R1: A blocked pulse on a port, with no success pulse on that port in the same cycle, raises that port's tally by one.
- R2: A success pulse on a port lowers that port's tally by one. A success and a blocked pulse in the same cycle leave the tally unchanged.
- R3: Tallies are CNT_W-bit two's complement values that stop at +(2^(CNT_W-1)-1) and -(2^(CNT_W-1)) instead of wrapping.
- R4: At an evaluation, an input tally that is high together with an output tally that is low yields a step_up pulse.
- R5: At an evaluation, an output tally that is high together with an input tally that is low yields a step_down pulse.
- R6: At an evaluation where both tallies are high, or both are low, neither request is raised.
- R7: A tally is high only when it is strictly greater than the signed threshold. A tally equal to the threshold is low.
- R8: A decision is taken only in a cycle with eval_strobe high. It uses the tallies built from events before that cycle, clears both tallies to zero, and discards the port events of the strobe cycle itself.
- R9: step_up and step_down are low after reset. They are registered, appear in the cycle right after the strobe, last exactly one cycle, and are never high together.

Parameter: CNT_W (default 8), the tally and threshold width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_blocked | input | 1 | Input port attempt blocked this cycle |
| in_success | input | 1 | Input port transfer completed this cycle |
| out_blocked | input | 1 | Output port attempt blocked this cycle |
| out_success | input | 1 | Output port transfer completed this cycle |
| threshold | input | CNT_W | Signed high/low boundary |
| eval_strobe | input | 1 | Take a decision and restart both tallies |
| step_up | output | 1 | One-cycle request for a faster clock step |
| step_down | output | 1 | One-cycle request for a slower clock step |

## Verification
A port event changes its tally at the next clock edge, so it counts toward a strobe given in any later cycle. The request caused by a strobe shows up one cycle after that strobe. The bench drives inputs on the falling edge and advances a behavioural model of integer tallies on the rising edge. It compares both request outputs with the model at the following falling edge, which catches any request that comes a cycle early or late. Directed windows aim at each decision case, at the threshold equality, at saturation and at strobe-cycle events, and a long pseudo-random run follows them.

// File: rtl/rmon_pkg.sv
package rmon_pkg;

    typedef enum logic [1:0] {
        DIR_HOLD  = 2'd0,
        DIR_RAISE = 2'd1,
        DIR_LOWER = 2'd2
    } rate_dir_e;

    typedef struct packed {
        logic inp_high;
        logic outp_high;
    } level_pair_t;

    localparam int PORT_IN  = 0;
    localparam int PORT_OUT = 1;
    localparam int NUM_PORTS = 2;

    function automatic rate_dir_e pick_dir(level_pair_t lv);
        rate_dir_e d;
        case ({lv.inp_high, lv.outp_high})
            2'b10:   d = DIR_RAISE;
            2'b01:   d = DIR_LOWER;
            default: d = DIR_HOLD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rmon_tally.sv
module rmon_tally #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                inc,
    input  logic                dec,
    output logic signed [W-1:0] cnt
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] ONE  = 1;

    logic signed [W-1:0] nxt;

    always_comb begin
        nxt = cnt;
        if (inc && !dec && cnt != MAXV) nxt = cnt + ONE;
        else if (dec && !inc && cnt != MINV) nxt = cnt - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= nxt;
    end

    // R1: one blocked event moves the tally up by one below the ceiling
    p_up_one_r1: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && !dec && cnt != MAXV) |=> cnt == $past(cnt) + ONE);
    // R2: one success event moves the tally down by one above the floor
    p_down_one_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && dec && !inc && cnt != MINV) |=> cnt == $past(cnt) - ONE);
    p_cancel_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && dec) |=> $stable(cnt));
    // R3: no wrap at either limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == MAXV && !dec) |=> cnt == MAXV);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == MINV && !inc) |=> cnt == MINV);
    // R8: strobe clears the tally
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/rmon_judge.sv
module rmon_judge
    import rmon_pkg::*;
#(
    parameter int W = 8
) (
    input  logic signed [W-1:0] cnt_in,
    input  logic signed [W-1:0] cnt_out,
    input  logic signed [W-1:0] thr,
    output rate_dir_e           dir
);
    level_pair_t lv;

    always_comb begin
        lv.inp_high  = (cnt_in  > thr);
        lv.outp_high = (cnt_out > thr);
        dir          = pick_dir(lv);
    end

endmodule

// File: rtl/rate_blockage_monitor.sv
module rate_blockage_monitor
    import rmon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_blocked,
    input  logic                    in_success,
    input  logic                    out_blocked,
    input  logic                    out_success,
    input  logic signed [CNT_W-1:0] threshold,
    input  logic                    eval_strobe,
    output logic                    step_up,
    output logic                    step_down
);
    logic [NUM_PORTS-1:0] blk_v;
    logic [NUM_PORTS-1:0] suc_v;
    logic signed [CNT_W-1:0] tally [NUM_PORTS];
    rate_dir_e dir;

    assign blk_v = {out_blocked, in_blocked};
    assign suc_v = {out_success, in_success};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rmon_tally #(.W(CNT_W)) u_tally (
            .clk (clk),
            .rst (rst),
            .clr (eval_strobe),
            .inc (blk_v[p]),
            .dec (suc_v[p]),
            .cnt (tally[p])
        );
    end

    rmon_judge #(.W(CNT_W)) u_judge (
        .cnt_in  (tally[PORT_IN]),
        .cnt_out (tally[PORT_OUT]),
        .thr     (threshold),
        .dir     (dir)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step_up   <= 1'b0;
            step_down <= 1'b0;
        end else begin
            step_up   <= eval_strobe && (dir == DIR_RAISE);
            step_down <= eval_strobe && (dir == DIR_LOWER);
        end
    end

    // R9: requests are exclusive and single-cycle
    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(step_up && step_down));
    p_up_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        step_up |=> !step_up);
    p_down_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        step_down |=> !step_down);
    // R8: a request only follows a strobe
    p_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_down) |-> $past(eval_strobe));
    // R4: starved input with free output asks for speed
    p_raise_r4: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && tally[PORT_IN] > threshold && !(tally[PORT_OUT] > threshold))
        |=> step_up);
    // R5: stalled output with free input asks for less speed
    p_lower_r5: assert property (@(posedge clk) disable iff (rst)
        (eval_strobe && tally[PORT_OUT] > threshold && !(tally[PORT_IN] > threshold))
        |=> step_down);

endmodule

// File: tb/tb_rate_blockage_monitor.sv
module tb_rate_blockage_monitor;
    localparam int W = 8;
    localparam int MAXI = (1 << (W-1)) - 1;
    localparam int MINI = -(1 << (W-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ib = 1'b0, is = 1'b0, ob = 1'b0, os = 1'b0, stb = 1'b0;
    logic signed [W-1:0] thr = '0;
    logic up, dn;

    int tests = 0;
    int fails = 0;
    int m_in = 0, m_out = 0;
    bit e_up = 0, e_dn = 0;
    string req = "R9";
    int seed = 7;

    always #2 clk = ~clk;  // 250 MHz

    rate_blockage_monitor #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst),
        .in_blocked(ib), .in_success(is),
        .out_blocked(ob), .out_success(os),
        .threshold(thr), .eval_strobe(stb),
        .step_up(up), .step_down(dn)
    );

    function automatic int clampi(int v);
        if (v > MAXI) return MAXI;
        if (v < MINI) return MINI;
        return v;
    endfunction

    task automatic check();
        tests++;
        if (up !== e_up || dn !== e_dn) begin
            fails++;
            $display("FAIL %s: up/down actual=%b%b expected=%b%b at %0t",
                     req, up, dn, e_up, e_dn, $time);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic tick(bit a, bit b, bit c, bit d, bit s);
        int t;
        ib = a; is = b; ob = c; os = d; stb = s;
        @(posedge clk);
        t = int'(thr);
        if (rst) begin
            m_in = 0; m_out = 0; e_up = 0; e_dn = 0;
        end else if (s) begin
            e_up = (m_in > t) && !(m_out > t);
            e_dn = (m_out > t) && !(m_in > t);
            m_in = 0; m_out = 0;
        end else begin
            e_up = 0; e_dn = 0;
            m_in  = clampi(m_in + int'(a) - int'(b));
            m_out = clampi(m_out + int'(c) - int'(d));
        end
        @(negedge clk);
        check();
    endtask

    task automatic burst(bit a, bit b, bit c, bit d, int n);
        for (int i = 0; i < n; i++) tick(a, b, c, d, 1'b0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        req = "R9";  // reset state
        burst(1, 0, 1, 0, 3);
        rst = 1'b0;
        tick(0, 0, 0, 0, 0);

        req = "R4"; thr = 8'sd2;   // in 3 > 2, out 0 -> up
        burst(1, 0, 0, 0, 3); tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);

        req = "R7"; thr = 8'sd3;   // in == thr is low -> hold
        burst(1, 0, 0, 0, 3); tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);

        req = "R1"; thr = 8'sd3;   // one more blocked -> high
        burst(1, 0, 0, 0, 4); tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);

        req = "R2"; thr = 8'sd1;   // 5 blocked, 3 success, 2 cancelled -> 2
        burst(1, 0, 0, 0, 5); burst(0, 1, 0, 0, 3); burst(1, 1, 0, 0, 2);
        tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);
        req = "R2"; thr = 8'sd2;
        burst(1, 0, 0, 0, 5); burst(0, 1, 0, 0, 3);
        tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);

        req = "R5"; thr = 8'sd0;
        burst(0, 0, 1, 0, 4); tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);

        req = "R6"; thr = 8'sd1;   // both high
        burst(1, 0, 1, 0, 4); tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);
        req = "R6"; thr = 8'sd5;   // both low
        burst(1, 0, 1, 0, 4); tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);

        req = "R3"; thr = -8'sd1;  // 200 up saturates at 127, 127 down -> 0
        burst(1, 0, 0, 0, 200); burst(0, 1, 0, 1, 127);
        tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);
        req = "R3"; thr = -8'sd2;  // floor at -128
        burst(0, 1, 1, 0, 200); burst(1, 0, 0, 0, 3);
        tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);

        req = "R8"; thr = 8'sd0;   // strobe-cycle events dropped, then cleared
        tick(1, 0, 0, 0, 1); tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);
        burst(1, 0, 0, 0, 2); tick(0, 0, 1, 0, 1); tick(0, 0, 0, 0, 1);
        tick(0, 0, 0, 0, 0);

        req = "R9";                // pseudo-random traffic
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom(seed + k);
            if (k % 64 == 0) thr = 8'($signed(r[7:0]) >>> 3);
            tick(r[8], r[9] & r[10], r[11], r[12] & r[13], r[20:16] == 5'd0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule